// File: doc/BRIEF.md
# Match-Compare Operating-System Timer with Watchdog

This block is the system tick source of a processor subsystem. A single free-running up-counter advances by one on every cycle in which the tick-enable input is high; the divider or prescaler that produces that tick lives outside the block. Four match channels each hold a compare value. When the counter steps onto a channel's value and that channel's interrupt enable is set, the channel latches a pending bit and drives its own interrupt line. Software acknowledges an interrupt by writing a one to the pending bit.

Software reaches every register through a plain single-cycle register port: a write strobe, a byte address and write data, with read data returned combinationally for the address presented. Software may also load the counter directly, and later matches are then counted from the loaded value. The last match channel doubles as a watchdog. Once software arms it, a hit on that channel raises a system-reset request that stays high until the block itself is reset. After arming, software cannot disarm the watchdog.

Top module: `os_match_timer`

## Requirements
- R1: After reset, the counter, all match values, the interrupt-enable register, the status register, the watchdog-arm bit, `irq_o` and `wdog_rst_o` all read or drive zero.
- R2: The counter (offset 0x10) rises by exactly one on each clock edge at which `tick_en_i` is high, holds when it is low, and wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x10 loads the counter and takes priority over a tick in the same cycle. Loading a value equal to a match value does not cause a hit. Later hits are counted from the loaded value.
- R4: Channel n (match value at offset 0x00 + 4*n) hits when a tick moves the counter onto its match value. The hit sets status bit n (offset 0x14, bit n) only if interrupt-enable bit n (offset 0x1C, bit n) is set.
- R5: `irq_o[n]` is high exactly while status bit n is set.
- R6: Writing offset 0x14 clears each status bit whose written bit is 1. Bits written as 0 keep their value.
- R7: When a hit on channel n and a write-one-to-clear of bit n fall on the same clock edge, the bit ends up set.
- R8: The interrupt-enable register keeps written bits [11:0] and reads back with bits [31:12] as zero.
- R9: Each match register reads back the last value written to it.
- R10: Writing a 1 to bit 0 of offset 0x18 arms the watchdog, and the bit reads back as 1. Writing a 0 leaves it armed. Only reset disarms it.
- R11: If the watchdog is armed when channel 3 hits, `wdog_rst_o` goes high on that same clock edge, whatever the value of interrupt-enable bit 3. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en_i | input | 1 | Counter advance enable, one count per high cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 4 | Per-channel interrupt lines |
| wdog_rst_o | output | 1 | Watchdog system-reset request |

## Verification
Two events can land on the same clock edge: a channel hit that sets a status bit, and a software write that clears that same bit. The bench provokes this by parking the counter one below a match value, then asserting the tick and a write-one-to-clear of that bit in one cycle. It then expects the bit and its interrupt line to remain high. A second overlap, a counter load on the same edge as a tick, is judged by reading the counter back and confirming it holds the loaded value.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_MATCH0 = 8'h00;
  localparam logic [7:0] OFS_COUNT  = 8'h10;
  localparam logic [7:0] OFS_STAT   = 8'h14;
  localparam logic [7:0] OFS_WDOG   = 8'h18;
  localparam logic [7:0] OFS_IEN    = 8'h1C;
  localparam int unsigned MATCH_STRIDE = 4;
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         adv_o
);
  logic [W-1:0] cnt_q, cnt_d, cnt_inc;
  logic         adv;

  always_comb begin
    adv     = tick_i & ~ld_i;
    cnt_inc = cnt_q + W'(1);
    if (ld_i)
      cnt_d = ld_val_i;
    else if (adv)
      cnt_d = cnt_inc;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (ld_i | adv)
      cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_inc;
  assign adv_o     = adv;

  // R2: one step per tick
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_i) |=> (cnt_q == $past(cnt_q) + W'(1)));
  // R2: hold without tick
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ld_i) |=> $stable(cnt_q));
  // R3: load wins over tick
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (cnt_q == $past(ld_val_i)));
endmodule

// File: rtl/ostmr_chan.sv
module ostmr_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         adv_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic         ien_i,
  input  logic         clr_i,
  output logic [W-1:0] match_o,
  output logic         hit_o,
  output logic         stat_o
);
  logic [W-1:0] match_q;
  logic         stat_q, stat_d, hit;

  always_comb begin
    hit = adv_i & (cnt_nxt_i == match_q);
    if (hit & ien_i)
      stat_d = 1'b1;
    else if (clr_i)
      stat_d = 1'b0;
    else
      stat_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      match_q <= '0;
    else if (wr_i)
      match_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat_q <= 1'b0;
    else
      stat_q <= stat_d;
  end

  assign match_o = match_q;
  assign hit_o   = hit;
  assign stat_o  = stat_q;

  // R4 / R7: an enabled hit always leaves the bit set
  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ien_i) |=> stat_q);
  // R6: clear without a competing hit
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(hit && ien_i)) |=> !stat_q);
  // R4: bit rises only through an enabled hit
  a_r4_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(hit && ien_i));
  // R9: match register updates only on write
  a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(match_q));
endmodule

// File: rtl/ostmr_wdog.sv
module ostmr_wdog (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wr_i,
  input  logic arm_bit_i,
  input  logic hit_i,
  output logic armed_o,
  output logic rst_req_o
);
  logic armed_q, armed_d, req_q, req_d;

  always_comb begin
    armed_d = armed_q | (arm_wr_i & arm_bit_i);
    req_d   = req_q | (armed_q & hit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      req_q   <= req_d;
    end
  end

  assign armed_o   = armed_q;
  assign rst_req_o = req_q;

  // R10: armed is sticky
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  // R11: request held until reset
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> req_q);
  // R11: armed hit fires the request
  a_r11_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && hit_i) |=> req_q);
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_CHAN = 4,
  parameter int unsigned IEN_W  = 12,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [N_CHAN-1:0] irq_o,
  output logic              wdog_rst_o
);
  import ostmr_pkg::*;

  localparam int unsigned WDOG_CH = N_CHAN - 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // address decode
  logic wr_cnt, wr_stat, wr_wdog, wr_ien;
  always_comb begin
    wr_cnt  = reg_wr_i & (reg_addr_i == ADDR_W'(OFS_COUNT));
    wr_stat = reg_wr_i & (reg_addr_i == ADDR_W'(OFS_STAT));
    wr_wdog = reg_wr_i & (reg_addr_i == ADDR_W'(OFS_WDOG));
    wr_ien  = reg_wr_i & (reg_addr_i == ADDR_W'(OFS_IEN));
  end

  // interrupt-enable register
  logic [IEN_W-1:0] ien_q, ien_d;
  always_comb ien_d = wr_ien ? reg_wdata_i[IEN_W-1:0] : ien_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)
      ien_q <= '0;
    else if (wr_ien)
      ien_q <= ien_d;
  end

  // counter
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             adv;

  ostmr_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .tick_i   (tick_en_i),
    .ld_i     (wr_cnt),
    .ld_val_i (reg_wdata_i),
    .cnt_o    (cnt),
    .cnt_nxt_o(cnt_nxt),
    .adv_o    (adv)
  );

  // match channels
  logic [CNT_W-1:0]  match_v [N_CHAN];
  logic [N_CHAN-1:0] hit_v, stat_v, clr_v;

  assign clr_v = wr_stat ? reg_wdata_i[N_CHAN-1:0] : '0;

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    logic wr_m;
    assign wr_m = reg_wr_i &
                  (reg_addr_i == ADDR_W'(OFS_MATCH0) + ADDR_W'(MATCH_STRIDE * g));
    ostmr_chan #(.W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .wr_i     (wr_m),
      .wdata_i  (reg_wdata_i),
      .adv_i    (adv),
      .cnt_nxt_i(cnt_nxt),
      .ien_i    (ien_q[g]),
      .clr_i    (clr_v[g]),
      .match_o  (match_v[g]),
      .hit_o    (hit_v[g]),
      .stat_o   (stat_v[g])
    );
  end

  // watchdog on the last channel
  logic armed;
  ostmr_wdog u_wdog (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .arm_wr_i (wr_wdog),
    .arm_bit_i(reg_wdata_i[0]),
    .hit_i    (hit_v[WDOG_CH]),
    .armed_o  (armed),
    .rst_req_o(wdog_rst_o)
  );

  assign irq_o = stat_v;

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < int'(N_CHAN); i++)
      if (reg_addr_i == ADDR_W'(OFS_MATCH0) + ADDR_W'(MATCH_STRIDE * i))
        reg_rdata_o = match_v[i];
    case (reg_addr_i)
      ADDR_W'(OFS_COUNT): reg_rdata_o = cnt;
      ADDR_W'(OFS_STAT):  reg_rdata_o = CNT_W'(stat_v);
      ADDR_W'(OFS_WDOG):  reg_rdata_o = CNT_W'(armed);
      ADDR_W'(OFS_IEN):   reg_rdata_o = CNT_W'(ien_q);
      default: ;
    endcase
  end

  // R8: enable register changes only on its own write
  a_r8_ien_keep: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_ien |=> $stable(ien_q));
  // R5: interrupt lines never show a bit not pending in status
  a_r5_irq_vs_stat: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_addr_i == ADDR_W'(OFS_STAT)) |-> (reg_rdata_o[N_CHAN-1:0] == irq_o));
endmodule

// File: tb/os_match_timer_bench.sv
module os_match_timer_bench;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IQ = 2'd3;
  typedef logic [73:0] vec_t; // op, addr, data, exp

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    {OP_WR, 8'h1C, 32'hFFFF_FFFF, 32'h0},       // R8
    {OP_RD, 8'h1C, 32'h0, 32'h0000_0FFF},       // R8
    {OP_WR, 8'h10, 32'd100, 32'h0},             // R3
    {OP_RD, 8'h10, 32'h0, 32'd100},             // R3
    {OP_WR, 8'h00, 32'd105, 32'h0},
    {OP_WR, 8'h04, 32'd103, 32'h0},
    {OP_RD, 8'h00, 32'h0, 32'd105},             // R9
    {OP_TK, 8'h00, 32'd3, 32'h0},               // R2
    {OP_RD, 8'h10, 32'h0, 32'd103},             // R2
    {OP_RD, 8'h14, 32'h0, 32'h2},               // R4
    {OP_IQ, 8'h00, 32'h0, 32'h2},               // R5
    {OP_TK, 8'h00, 32'd2, 32'h0},
    {OP_RD, 8'h14, 32'h0, 32'h3},               // R4
    {OP_WR, 8'h14, 32'h1, 32'h0},               // R6
    {OP_RD, 8'h14, 32'h0, 32'h2},               // R6
    {OP_IQ, 8'h00, 32'h0, 32'h2},               // R5
    {OP_WR, 8'h14, 32'h0, 32'h0},               // R6 zeros
    {OP_RD, 8'h14, 32'h0, 32'h2},               // R6
    {OP_WR, 8'h14, 32'h2, 32'h0},
    {OP_RD, 8'h14, 32'h0, 32'h0},               // R6
    {OP_WR, 8'h1C, 32'h0000_0FFB, 32'h0},       // R4 ch2 disabled
    {OP_WR, 8'h08, 32'd110, 32'h0},
    {OP_TK, 8'h00, 32'd5, 32'h0},
    {OP_RD, 8'h14, 32'h0, 32'h0},               // R4
    {OP_WR, 8'h10, 32'd105, 32'h0},             // R3 load onto match
    {OP_RD, 8'h14, 32'h0, 32'h0},               // R3
    {OP_WR, 8'h10, 32'd200, 32'h0},
    {OP_WR, 8'h00, 32'd204, 32'h0},
    {OP_TK, 8'h00, 32'd3, 32'h0},
    {OP_RD, 8'h14, 32'h0, 32'h0},               // R3
    {OP_TK, 8'h00, 32'd1, 32'h0},
    {OP_IQ, 8'h00, 32'h0, 32'h1},               // R3
    {OP_WR, 8'h14, 32'hF, 32'h0},
    {OP_WR, 8'h10, 32'hFFFF_FFFE, 32'h0},       // R2 wrap
    {OP_WR, 8'h04, 32'h0, 32'h0},
    {OP_TK, 8'h00, 32'd2, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en_i, reg_wr_i;
  logic [7:0]  reg_addr_i;
  logic [31:0] reg_wdata_i, reg_rdata_o;
  logic [3:0]  irq_o;
  logic        wdog_rst_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  os_match_timer u_os_match_timer (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    check(req, reg_rdata_o, exp);
  endtask

  task automatic tk(input int n);
    @(negedge clk);
    tick_en_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_en_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick_en_i = 1'b0; reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    do_reset();
    // R1: reset state
    rd("R1", 8'h00, 32'h0); rd("R1", 8'h0C, 32'h0); rd("R1", 8'h10, 32'h0);
    rd("R1", 8'h14, 32'h0); rd("R1", 8'h18, 32'h0); rd("R1", 8'h1C, 32'h0);
    check("R1", {28'h0, irq_o}, 32'h0);
    check("R1", {31'h0, wdog_rst_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][73:72])
        OP_WR: wr(VEC[i][71:64], VEC[i][63:32]);
        OP_RD: rd("R2/R3/R4/R6/R8/R9 table", VEC[i][71:64], VEC[i][31:0]);
        OP_TK: tk(int'(VEC[i][63:32]));
        default: begin #1; check("R5 table", {28'h0, irq_o}, VEC[i][31:0]); end
      endcase
    end
    // R2 wrap: counter 0, channels 1 and 3 (both match 0) hit
    rd("R2", 8'h10, 32'h0);
    rd("R4", 8'h14, 32'hA);
    rd("R9", 8'h04, 32'h0);
    wr(8'h14, 32'hF);

    // R7: hit and clear on the same edge
    wr(8'h10, 32'd300);
    wr(8'h04, 32'd301);
    @(negedge clk);
    tick_en_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 8'h14; reg_wdata_i = 32'h2;
    @(negedge clk);
    tick_en_i = 1'b0; reg_wr_i = 1'b0;
    rd("R7", 8'h14, 32'h2);
    check("R7", {28'h0, irq_o}, 32'h2);
    // R3: load beats tick
    @(negedge clk);
    tick_en_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 8'h10; reg_wdata_i = 32'd400;
    @(negedge clk);
    tick_en_i = 1'b0; reg_wr_i = 1'b0;
    rd("R3", 8'h10, 32'd400);
    wr(8'h14, 32'hF);

    // R10 / R11: watchdog, channel 3 interrupt disabled
    wr(8'h1C, 32'h7);
    wr(8'h0C, 32'd402);
    wr(8'h18, 32'h1);
    rd("R10", 8'h18, 32'h1);
    wr(8'h18, 32'h0);
    rd("R10", 8'h18, 32'h1);
    tk(1);
    #1 check("R11", {31'h0, wdog_rst_o}, 32'h0);
    tk(1);
    #1 check("R11", {31'h0, wdog_rst_o}, 32'h1);
    rd("R4", 8'h14, 32'h0);
    tk(3);
    #1 check("R11", {31'h0, wdog_rst_o}, 32'h1);
    do_reset();
    check("R11", {31'h0, wdog_rst_o}, 32'h0);
    rd("R10", 8'h18, 32'h0);
    rd("R1", 8'h0C, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule